// File: doc/BRIEF.md
# SPI Receive-Only Byte Request Packer

This block runs the receive-only side of an SPI master. With the transmitter switched off, software writes a byte count. The block then holds its shift-enable output high until that many bytes have arrived from the serial shift engine. The programmed word length plays no part here. Incoming bytes are always gathered into 32-bit entries of a small receive FIFO held inside the block, and the first byte of an entry lands in the upper bits.

The block keeps a down-counter of the bytes still outstanding. When the count runs out before an entry holds four bytes, that entry is closed early. It is tagged with the number of bytes it really holds, and those bytes are right-aligned. Software reads the head entry and its valid-byte tag and pops it. It watches the FIFO fill level or a receive interrupt, which fires once the level reaches a programmable threshold. An entry that completes while the FIFO is full is lost, and a sticky overflow flag records the loss.

Top module: `spi_rxonly_packer`

## Requirements
- R1: After reset, the remaining count, FIFO level, shift enable, receive interrupt and overflow flag are all zero.
- R2: A request write loads its count only while `tx_off` is 1, and is ignored while `tx_off` is 0. `shift_en` is 1 exactly when the remaining count is nonzero.
- R3: Each byte strobe taken while the remaining count is nonzero lowers the count by one. A strobe while the count is zero changes neither the count nor the FIFO.
- R4: A full entry holds four bytes with the first received byte in bits 31:24 and the fourth in bits 7:0, and its valid-byte tag reads 4.
- R5: When the count reaches zero with one to three bytes gathered, those bytes are pushed as one entry. The last byte sits in bits 7:0 and earlier bytes sit above it, the unused upper bits are zero, and the tag gives the byte count (1 to 3).
- R6: A request written while the remaining count is nonzero adds its count to the bytes still outstanding.
- R7: `rx_level` gives the number of stored entries. A pop removes the head entry in arrival order, and a pop on an empty FIFO has no effect.
- R8: `rx_irq` is 1 when `irq_level` is nonzero and `rx_level` is at least `irq_level`.
- R9: An entry completing while the FIFO is full is discarded and sets `rx_overflow`, while the remaining count still decrements. The flag stays set until `ovf_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_off | input | 1 | Transmitter switched off (receive-only operation allowed) |
| req_we | input | 1 | Request write strobe |
| req_cnt | input | CNT_W | Number of bytes requested |
| shift_en | output | 1 | Shift clock generation enable for the shift engine |
| byte_stb | input | 1 | One received byte is valid on byte_data |
| byte_data | input | 8 | Received byte |
| rx_pop | input | 1 | Remove the head FIFO entry |
| rx_data | output | 32 | Head FIFO entry (zero when empty) |
| rx_nbytes | output | 3 | Valid bytes in the head entry (zero when empty) |
| rx_level | output | 6 | Number of stored entries |
| irq_level | input | 6 | Receive interrupt threshold |
| rx_irq | output | 1 | Receive interrupt |
| rx_overflow | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| remaining | output | CNT_W | Bytes still to be received |

## Verification
The bench builds the block with a FIFO depth of 4 and a 16-bit count. With a depth this small, a single 20-byte request fills the FIFO and produces a fifth entry that must be dropped, which exercises the overflow path and the way the count keeps falling during it. An interrupt threshold of 2 can be crossed after two entries. A request split across two writes yields one full entry and one three-byte tail.

// File: rtl/spi_rxonly_packer.sv
module spi_rxonly_packer #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_off,
  input  logic             req_we,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             shift_en,
  input  logic             byte_stb,
  input  logic [7:0]       byte_data,
  input  logic             rx_pop,
  output logic [31:0]      rx_data,
  output logic [2:0]       rx_nbytes,
  output logic [5:0]       rx_level,
  input  logic [5:0]       irq_level,
  output logic             rx_irq,
  output logic             rx_overflow,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] remaining
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] rem_q;
  logic [1:0]       bcnt_q;
  logic [23:0]      acc_q;
  logic [31:0]      word_mem [DEPTH];
  logic [2:0]       nb_mem   [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [LW-1:0]    cnt_q;
  logic             ovf_q;

  logic req_ok, take, last, full, push, drop, pop_ok;

  assign req_ok = req_we & tx_off;
  assign take   = byte_stb & (rem_q != '0);
  assign last   = take & ((bcnt_q == 2'd3) | ((rem_q == CNT_W'(1)) & ~req_ok));
  assign full   = (cnt_q == LW'(DEPTH));
  assign push   = last & ~full;
  assign drop   = last & full;
  assign pop_ok = rx_pop & (cnt_q != '0);

  assign remaining   = rem_q;
  assign shift_en    = (rem_q != '0);
  assign rx_level    = 6'(cnt_q);
  assign rx_data     = (cnt_q != '0) ? word_mem[rp_q] : 32'd0;
  assign rx_nbytes   = (cnt_q != '0) ? nb_mem[rp_q] : 3'd0;
  assign rx_irq      = (irq_level != 6'd0) & (rx_level >= irq_level);
  assign rx_overflow = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_q + (req_ok ? req_cnt : '0) - (take ? CNT_W'(1) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bcnt_q <= '0;
    end else if (take) begin
      if (last) begin
        acc_q  <= '0;
        bcnt_q <= '0;
      end else begin
        acc_q  <= {acc_q[15:0], byte_data};
        bcnt_q <= bcnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      word_mem[wp_q] <= {acc_q, byte_data};
      nb_mem[wp_q]   <= {1'b0, bcnt_q} + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (pop_ok) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      cnt_q <= cnt_q + (push ? LW'(1) : '0) - (pop_ok ? LW'(1) : '0);
      if (drop) ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  AST_REM_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_ok) |=> (remaining == $past(remaining) - CNT_W'(1))); // R3
  AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_stb && !req_we) |=> $stable(remaining)); // R3
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && !tx_off && !byte_stb) |=> $stable(remaining)); // R2
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= 6'(DEPTH)); // R7
  AST_NBYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level != 6'd0) |-> (rx_nbytes >= 3'd1 && rx_nbytes <= 3'd4)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && !ovf_clr) |=> rx_overflow); // R9
  AST_DROP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rx_pop) |=> $stable(rx_level)); // R9
endmodule

// File: tb/tb_spi_rxonly_packer.sv
`timescale 1ns/1ps
module tb_spi_rxonly_packer;
  logic        clk = 0, rst_n = 0;
  logic        tx_off = 0, req_we = 0, byte_stb = 0, rx_pop = 0, ovf_clr = 0;
  logic [15:0] req_cnt = 0;
  logic [7:0]  byte_data = 0;
  logic [5:0]  irq_level = 0;
  logic        shift_en, rx_irq, rx_overflow;
  logic [31:0] rx_data;
  logic [2:0]  rx_nbytes;
  logic [5:0]  rx_level;
  logic [15:0] remaining;
  int tests = 0, fails = 0;
  bit done = 0;

  spi_rxonly_packer #(.DEPTH(4), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .tx_off(tx_off), .req_we(req_we), .req_cnt(req_cnt),
    .shift_en(shift_en), .byte_stb(byte_stb), .byte_data(byte_data), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_nbytes(rx_nbytes), .rx_level(rx_level), .irq_level(irq_level),
    .rx_irq(rx_irq), .rx_overflow(rx_overflow), .ovf_clr(ovf_clr), .remaining(remaining));

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic request(logic [15:0] n);
    req_we = 1; req_cnt = n; @(posedge clk); #1; req_we = 0;
  endtask
  task automatic send(logic [7:0] b);
    byte_stb = 1; byte_data = b; @(posedge clk); #1; byte_stb = 0;
  endtask
  task automatic pop1();
    rx_pop = 1; @(posedge clk); #1; rx_pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 remaining", remaining, 0);
    chk("R1 level", rx_level, 0);
    chk("R1 shift_en", shift_en, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 overflow", rx_overflow, 0);
  endtask

  task automatic t_request_gate();
    tx_off = 0; request(5);
    chk("R2 ignored with tx on", remaining, 0);
    chk("R2 shift_en off", shift_en, 0);
    tx_off = 1; request(6);
    chk("R2 loaded", remaining, 6);
    chk("R2 shift_en on", shift_en, 1);
  endtask

  task automatic t_full_and_partial();
    send(8'hAA); send(8'hBB); send(8'hCC);
    chk("R3 decrement", remaining, 3);
    send(8'hDD);
    chk("R4 level", rx_level, 1);
    chk("R4 data", rx_data, 32'hAABBCCDD);
    chk("R4 nbytes", rx_nbytes, 4);
    send(8'h11); send(8'h22);
    chk("R3 reached zero", remaining, 0);
    chk("R2 shift_en drops", shift_en, 0);
    chk("R5 level", rx_level, 2);
    pop1();
    chk("R5 tail data", rx_data, 32'h00001122);
    chk("R5 tail nbytes", rx_nbytes, 2);
    send(8'h99);
    chk("R3 stray byte count", remaining, 0);
    chk("R3 stray byte fifo", rx_level, 1);
    pop1();
    chk("R7 empty", rx_level, 0);
    pop1();
    chk("R7 pop on empty", rx_level, 0);
  endtask

  task automatic t_add();
    request(3); send(8'h31);
    request(4);
    chk("R6 added", remaining, 6);
    send(8'h32); send(8'h33); send(8'h34);
    send(8'h35); send(8'h36); send(8'h37);
    chk("R6 drained", remaining, 0);
    chk("R7 level two", rx_level, 2);
    chk("R6 first word", rx_data, 32'h31323334);
    pop1();
    chk("R5 three-byte tail", rx_data, 32'h00353637);
    chk("R5 tail nbytes 3", rx_nbytes, 3);
    pop1();
  endtask

  task automatic t_irq();
    irq_level = 2; #1;
    chk("R8 below threshold empty", rx_irq, 0);
    request(8);
    for (int i = 0; i < 4; i++) send(8'(i));
    chk("R8 one entry", rx_irq, 0);
    for (int i = 0; i < 4; i++) send(8'(i));
    chk("R8 threshold reached", rx_irq, 1);
    irq_level = 0; #1;
    chk("R8 zero threshold", rx_irq, 0);
    pop1(); pop1();
  endtask

  task automatic t_overflow();
    request(20);
    for (int i = 1; i <= 20; i++) send(8'(i));
    chk("R9 count still reaches zero", remaining, 0);
    chk("R9 level full", rx_level, 4);
    chk("R9 flag", rx_overflow, 1);
    chk("R7 order first", rx_data, 32'h01020304);
    pop1(); pop1(); pop1();
    chk("R9 last kept entry", rx_data, 32'h0D0E0F10);
    pop1();
    chk("R9 drained", rx_level, 0);
    chk("R9 flag sticky", rx_overflow, 1);
    ovf_clr = 1; @(posedge clk); #1; ovf_clr = 0;
    chk("R9 flag cleared", rx_overflow, 0);
  endtask

  initial begin
    #12; rst_n = 1; @(posedge clk); #1;
    t_reset();
    t_request_gate();
    t_full_and_partial();
    t_add();
    t_irq();
    t_overflow();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule